// File: doc/BRIEF.md
# Storage Controller Configuration Register File

This block is the register file that host software uses to bring up a queue-based storage controller. It answers to a simple write strobe, byte offset and 32-bit data, with a combinational read path on the same offset. It holds fixed capability and version words, an interrupt mask that is set and cleared through two separate offsets, the admin queue sizes and the two 64-bit admin queue base addresses, a configuration word and a status word.

The configuration word acts on its transitions, not as plain storage. When the enable bit turns on, the programmed setup is checked. The result is either a ready indication one cycle later or a fatal indication at once. When the enable bit turns off, the queue logic gets a reset pulse. A shutdown request raises a shutdown-complete status and also pulses reset. The queue engine sits next to this block and reports whether admin queues are still alive, which is one input to the check.

Top module: `stor_cfg_regs`

## Requirements
- R1: After reset, every writable register, the interrupt mask and the status word read 0, and both `queueReset` and `shutdownReq` are low.
- R2: Offset 0x00 reads 0x0F0307FF and offset 0x04 reads 0x00400020. These words give a queue-entry limit of 0x7FF, contiguous queues required, arbitration bit 17 set, timeout 0xF, command set bit 37 set, minimum page code 0 and maximum page code 4 in bits 55:52. Offset 0x08 reads 0x00010100. Writes to these three offsets change nothing.
- R3: A write to 0x0C ORs the data into the interrupt mask, and a write to 0x10 clears the bits that are set in the data. Both offsets always read the same current mask.
- R4: Offset 0x24 stores all 32 bits of the admin sizes, with the submission size in bits 11:0 and the completion size in bits 27:16. Offsets 0x28 and 0x2C hold the low and high words of the admin submission base, and 0x30 and 0x34 hold the low and high words of the admin completion base. Each word is written independently.
- R5: The configuration word at 0x14 has enable in bit 0, page code in bits 10:7, shutdown request in bits 15:14, submission entry exponent in bits 19:16 and completion entry exponent in bits 23:20. A write that turns enable on stores the whole word. The status word at 0x1C has ready in bit 0, fatal in bit 1 and shutdown-complete code 2'b10 in bits 3:2. After a passing check, ready reads 0 in the cycle right after the write and 1 from the cycle after that.
- R6: An enabling write fails, setting fatal and leaving ready at 0, if any of these holds: either base is zero; either base has a nonzero bit below bit 12+page code; the page code is above 4; the submission exponent is not 6; the completion exponent is not 4; either size field is zero.
- R7: An enabling write also fails when `queuesLive` is high.
- R8: A write that turns enable off sets the configuration word to 0 and clears ready. Fatal is kept. `queueReset` is high for exactly the one cycle after the write.
- R9: A configuration write that changes neither enable nor whether shutdown is requested (zero versus nonzero) leaves the configuration word and status unchanged and issues no pulse.
- R10: A configuration write whose shutdown field goes from zero to nonzero stores the word, sets the status shutdown code to 2'b10, and makes both `queueReset` and `shutdownReq` high for one cycle.
- R11: A configuration write whose shutdown field returns to zero stores the word, clears the shutdown code and issues no pulse.
- R12: Writes to any offset not listed above are ignored. Offsets 0x18, 0x20 and everything from 0x38 upward read 0. Address bits 1:0 are ignored, so a read at 0x0B returns the version word.
- R13: Ready and fatal are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte offset for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| queuesLive | input | 1 | Queue logic still holds admin queues |
| queueReset | output | 1 | One-cycle pulse that tears down all queues |
| shutdownReq | output | 1 | One-cycle pulse on a shutdown request |

## Verification
The assertions assume that `wrEn` is a single-cycle strobe that never lands on the enable offset in two consecutive cycles. They also assume that `queuesLive` changes only between configuration writes, so ready and fatal follow from one stable picture of the queue state. The stimulus honours this: each write is separated from the next by an idle cycle, and `queuesLive` is set before the enabling write and dropped only after the disabling one. The sweeps cover the page code, both entry exponents and base alignment over a 5 by 5 grid, so every failure cause is tried with the other causes held passing.

// File: rtl/stor_cfg_pkg.sv
package stor_cfg_pkg;

  // word indices (byte offset / 4) that software decodes
  localparam int WI_CAP_LO  = 0;
  localparam int WI_CAP_HI  = 1;
  localparam int WI_VERSION = 2;
  localparam int WI_MSK_SET = 3;
  localparam int WI_MSK_CLR = 4;
  localparam int WI_CFG     = 5;
  localparam int WI_STAT    = 7;
  localparam int WI_SIZES   = 9;
  localparam int WI_SQB_LO  = 10;
  localparam int WI_SQB_HI  = 11;
  localparam int WI_CQB_LO  = 12;
  localparam int WI_CQB_HI  = 13;

  localparam logic [31:0] VERSION_WORD = 32'h0001_0100;
  localparam logic [15:0] MAX_ENTRIES  = 16'h07FF;
  localparam logic [7:0]  TIMEOUT_CODE = 8'h0F;
  localparam logic [7:0]  CMDSET_MASK  = 8'h01;

  typedef struct packed {
    logic [7:0] rsvHi;
    logic [3:0] cqExp;
    logic [3:0] sqExp;
    logic [1:0] shut;
    logic [2:0] arb;
    logic [3:0] pageCode;
    logic [2:0] cmdSet;
    logic [2:0] rsvLo;
    logic       en;
  } cfgWord_t;

  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic sizesWr;
    logic sqbLoWr;
    logic sqbHiWr;
    logic cqbLoWr;
    logic cqbHiWr;
    logic cfgLoad;
    logic cfgZero;
    logic enStart;
    logic enFail;
    logic rdyClr;
    logic rdySet;
    logic shutSet;
    logic shutClr;
  } regStrobe_t;

  function automatic logic [63:0] buildCap(input logic [3:0] pgMin, input logic [3:0] pgMax);
    buildCap = {8'h00, pgMax, pgMin, 3'b000, CMDSET_MASK, 1'b0, 4'h0,
                TIMEOUT_CODE, 5'b00000, 2'b01, 1'b1, MAX_ENTRIES};
  endfunction

endpackage

// File: rtl/stor_cfg_validate.sv
module stor_cfg_validate
  import stor_cfg_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int MPS_MIN    = 0,
  parameter int MPS_MAX    = 4,
  parameter int SQES_REQ   = 6,
  parameter int CQES_REQ   = 4
) (
  input  cfgWord_t    newCfg,
  input  logic [31:0] sizes,
  input  logic [63:0] sqBase,
  input  logic [63:0] cqBase,
  input  logic        queuesLive,
  output logic        bad
);
  localparam int SHW = 7;

  logic [SHW-1:0] shAmt;
  logic [63:0]    pageMask;
  logic           baseBad;
  logic           pageBad;
  logic           expBad;
  logic           sizeBad;
  logic           unusedBits;

  assign shAmt    = SHW'(PAGE_SHIFT) + SHW'(newCfg.pageCode);
  assign pageMask = (64'd1 << shAmt) - 64'd1;

  always_comb begin
    baseBad = (sqBase == '0) || (cqBase == '0) ||
              ((sqBase & pageMask) != '0) || ((cqBase & pageMask) != '0);
    pageBad = (int'(newCfg.pageCode) < MPS_MIN) || (int'(newCfg.pageCode) > MPS_MAX);
    expBad  = (int'(newCfg.sqExp) != SQES_REQ) || (int'(newCfg.cqExp) != CQES_REQ);
    sizeBad = (sizes[11:0] == '0) || (sizes[27:16] == '0);
    bad     = baseBad | pageBad | expBad | sizeBad | queuesLive;
  end

  assign unusedBits = ^{newCfg.rsvHi, newCfg.shut, newCfg.arb, newCfg.cmdSet,
                        newCfg.rsvLo, newCfg.en, sizes[31:28], sizes[15:12]};
endmodule

// File: rtl/stor_cfg_ctl.sv
module stor_cfg_ctl
  import stor_cfg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_SHIFT = 12,
  parameter int MPS_MIN    = 0,
  parameter int MPS_MAX    = 4,
  parameter int SQES_REQ   = 6,
  parameter int CQES_REQ   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-3:0] wordIdx,
  input  logic [31:0]       wrData,
  input  cfgWord_t          cfgQ,
  input  logic [31:0]       sizesQ,
  input  logic [63:0]       sqBaseQ,
  input  logic [63:0]       cqBaseQ,
  input  logic              queuesLive,
  output regStrobe_t        strb,
  output logic              queueReset,
  output logic              shutdownReq
);
  localparam int IW = ADDR_W - 2;

  cfgWord_t   newCfg;
  logic       cfgHit;
  logic       enRise;
  logic       enFall;
  logic [1:0] shutAfterEn;
  logic       shutRise;
  logic       shutFall;
  logic       checkBad;
  logic       readyPend;

  assign newCfg = cfgWord_t'(wrData);

  stor_cfg_validate #(
    .PAGE_SHIFT(PAGE_SHIFT), .MPS_MIN(MPS_MIN), .MPS_MAX(MPS_MAX),
    .SQES_REQ(SQES_REQ), .CQES_REQ(CQES_REQ)
  ) u_val (
    .newCfg(newCfg), .sizes(sizesQ), .sqBase(sqBaseQ), .cqBase(cqBaseQ),
    .queuesLive(queuesLive), .bad(checkBad)
  );

  function automatic logic hit(input logic [IW-1:0] idx, input int wi);
    hit = (idx == IW'(wi));
  endfunction

  always_comb begin
    cfgHit      = wrEn && hit(wordIdx, WI_CFG);
    enRise      = cfgHit &&  newCfg.en && !cfgQ.en;
    enFall      = cfgHit && !newCfg.en &&  cfgQ.en;
    // shutdown field as it stands after the enable handling of this write
    shutAfterEn = enRise ? newCfg.shut : (enFall ? 2'b00 : cfgQ.shut);
    shutRise    = cfgHit && (newCfg.shut != 2'b00) && (shutAfterEn == 2'b00);
    shutFall    = cfgHit && (newCfg.shut == 2'b00) && (shutAfterEn != 2'b00);

    strb         = '0;
    strb.maskSet = wrEn && hit(wordIdx, WI_MSK_SET);
    strb.maskClr = wrEn && hit(wordIdx, WI_MSK_CLR);
    strb.sizesWr = wrEn && hit(wordIdx, WI_SIZES);
    strb.sqbLoWr = wrEn && hit(wordIdx, WI_SQB_LO);
    strb.sqbHiWr = wrEn && hit(wordIdx, WI_SQB_HI);
    strb.cqbLoWr = wrEn && hit(wordIdx, WI_CQB_LO);
    strb.cqbHiWr = wrEn && hit(wordIdx, WI_CQB_HI);
    strb.cfgLoad = enRise | shutRise | shutFall;
    strb.cfgZero = enFall & ~(shutRise | shutFall);
    strb.enStart = enRise;
    strb.enFail  = enRise & checkBad;
    strb.rdyClr  = enFall;
    strb.rdySet  = readyPend;
    strb.shutSet = shutRise;
    strb.shutClr = shutFall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyPend   <= 1'b0;
      queueReset  <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      readyPend   <= enRise & ~checkBad;
      queueReset  <= enFall | shutRise;
      shutdownReq <= shutRise;
    end
  end
endmodule

// File: rtl/stor_cfg_data.sv
module stor_cfg_data
  import stor_cfg_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter logic [63:0] CAP    = 64'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-3:0] wordIdx,
  output logic [31:0]       rdData,
  output cfgWord_t          cfgQ,
  output logic [31:0]       sizesQ,
  output logic [63:0]       sqBaseQ,
  output logic [63:0]       cqBaseQ,
  output logic [31:0]       maskQ,
  output logic              rdyQ,
  output logic              fatalQ,
  output logic [1:0]        shutQ
);
  localparam int IW = ADDR_W - 2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '0;
      sizesQ  <= '0;
      sqBaseQ <= '0;
      cqBaseQ <= '0;
      maskQ   <= '0;
      rdyQ    <= 1'b0;
      fatalQ  <= 1'b0;
      shutQ   <= 2'b00;
    end else begin
      if (strb.maskSet) maskQ <= maskQ | wrData;
      else if (strb.maskClr) maskQ <= maskQ & ~wrData;

      if (strb.sizesWr) sizesQ <= wrData;
      if (strb.sqbLoWr) sqBaseQ[31:0]  <= wrData;
      if (strb.sqbHiWr) sqBaseQ[63:32] <= wrData;
      if (strb.cqbLoWr) cqBaseQ[31:0]  <= wrData;
      if (strb.cqbHiWr) cqBaseQ[63:32] <= wrData;

      if (strb.cfgLoad) cfgQ <= cfgWord_t'(wrData);
      else if (strb.cfgZero) cfgQ <= '0;

      if (strb.enStart || strb.rdyClr) rdyQ <= 1'b0;
      else if (strb.rdySet) rdyQ <= 1'b1;

      if (strb.enStart) fatalQ <= strb.enFail;

      if (strb.shutSet) shutQ <= 2'b10;
      else if (strb.shutClr || strb.enStart) shutQ <= 2'b00;
    end
  end

  always_comb begin
    unique case (wordIdx)
      IW'(WI_CAP_LO):  rdData = CAP[31:0];
      IW'(WI_CAP_HI):  rdData = CAP[63:32];
      IW'(WI_VERSION): rdData = VERSION_WORD;
      IW'(WI_MSK_SET): rdData = maskQ;
      IW'(WI_MSK_CLR): rdData = maskQ;
      IW'(WI_CFG):     rdData = cfgQ;
      IW'(WI_STAT):    rdData = {28'd0, shutQ, fatalQ, rdyQ};
      IW'(WI_SIZES):   rdData = sizesQ;
      IW'(WI_SQB_LO):  rdData = sqBaseQ[31:0];
      IW'(WI_SQB_HI):  rdData = sqBaseQ[63:32];
      IW'(WI_CQB_LO):  rdData = cqBaseQ[31:0];
      IW'(WI_CQB_HI):  rdData = cqBaseQ[63:32];
      default:         rdData = '0;
    endcase
  end
endmodule

// File: rtl/stor_cfg_regs.sv
module stor_cfg_regs
  import stor_cfg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_SHIFT = 12,
  parameter int MPS_MIN    = 0,
  parameter int MPS_MAX    = 4,
  parameter int SQES_REQ   = 6,
  parameter int CQES_REQ   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              queuesLive,
  output logic              queueReset,
  output logic              shutdownReq
);
  localparam logic [63:0] CAP = buildCap(4'(MPS_MIN), 4'(MPS_MAX));

  regStrobe_t        strb;
  cfgWord_t          cfgQ;
  logic [31:0]       sizesQ;
  logic [63:0]       sqBaseQ;
  logic [63:0]       cqBaseQ;
  logic [31:0]       maskQ;
  logic              rdyQ;
  logic              fatalQ;
  logic [1:0]        shutQ;
  logic [ADDR_W-3:0] wordIdx;
  logic              unusedByteSel;

  assign wordIdx       = addr[ADDR_W-1:2];
  assign unusedByteSel = ^addr[1:0];

  stor_cfg_ctl #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .MPS_MIN(MPS_MIN),
    .MPS_MAX(MPS_MAX), .SQES_REQ(SQES_REQ), .CQES_REQ(CQES_REQ)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wordIdx(wordIdx), .wrData(wrData),
    .cfgQ(cfgQ), .sizesQ(sizesQ), .sqBaseQ(sqBaseQ), .cqBaseQ(cqBaseQ),
    .queuesLive(queuesLive), .strb(strb), .queueReset(queueReset),
    .shutdownReq(shutdownReq)
  );

  stor_cfg_data #(.ADDR_W(ADDR_W), .CAP(CAP)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .wordIdx(wordIdx),
    .rdData(rdData), .cfgQ(cfgQ), .sizesQ(sizesQ), .sqBaseQ(sqBaseQ),
    .cqBaseQ(cqBaseQ), .maskQ(maskQ), .rdyQ(rdyQ), .fatalQ(fatalQ), .shutQ(shutQ)
  );
endmodule

// File: rtl/stor_cfg_chk.sv
module stor_cfg_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       maskQ,
  input logic              cfgEn,
  input logic              rdy,
  input logic              fatal,
  input logic              queueReset,
  input logic              shutdownReq
);
  // R13
  rdy_fatal_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdy && fatal));

  // R10
  shut_has_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> queueReset);

  // R8
  fall_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgEn) |-> !rdy);

  // R5
  rdy_after_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdy) |-> ($past(cfgEn) && !fatal));

  // R8
  reset_from_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueReset |-> $past(wrEn));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[ADDR_W-1:2] == (ADDR_W-2)'(3)) |=>
      ((maskQ & $past(wrData)) == $past(wrData)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[ADDR_W-1:2] == (ADDR_W-2)'(4)) |=>
      ((maskQ & $past(wrData)) == 32'd0));
endmodule

bind stor_cfg_regs stor_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .maskQ(maskQ), .cfgEn(cfgQ.en), .rdy(rdyQ), .fatal(fatalQ),
  .queueReset(queueReset), .shutdownReq(shutdownReq)
);

// File: tb/sim_stor_cfg_regs.sv
`timescale 1ns/1ps
module sim_stor_cfg_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        queuesLive = 1'b0;
  logic        queueReset;
  logic        shutdownReq;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  localparam logic [31:0] GOOD = 32'h0046_0000; // cq exp 4, sq exp 6, page code 0

  always #2 clk = ~clk;

  stor_cfg_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .queuesLive(queuesLive), .queueReset(queueReset),
    .shutdownReq(shutdownReq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, $sformatf("read @%h", a), rdData, exp);
  endtask

  task automatic trial(input logic [63:0] sqb, input logic [63:0] cqb,
                       input logic [31:0] sizes, input logic [31:0] cfg,
                       input logic live, input string req);
    logic [6:0]  sh;
    logic [63:0] pm;
    bit          fail;
    sh = 7'd12 + 7'(cfg[10:7]);
    pm = (64'd1 << sh) - 64'd1;
    fail = (sqb == 0) || (cqb == 0) || ((sqb & pm) != 0) || ((cqb & pm) != 0) ||
           (cfg[10:7] > 4) || (cfg[19:16] != 6) || (cfg[23:20] != 4) ||
           (sizes[11:0] == 0) || (sizes[27:16] == 0) || live;
    wr(12'h024, sizes);
    wr(12'h028, sqb[31:0]);
    wr(12'h02C, sqb[63:32]);
    wr(12'h030, cqb[31:0]);
    wr(12'h034, cqb[63:32]);
    queuesLive = live;
    wr(12'h014, cfg | 32'd1);
    rdChk(req, 12'h01C, fail ? 32'h2 : 32'h0);          // ready still 0 (R5)
    tick();
    rdChk(req, 12'h01C, fail ? 32'h2 : 32'h1);
    chk("R13", "ready and fatal both set", 32'(rdData[1:0] == 2'b11), 32'd0);
    rdChk("R5", 12'h014, cfg | 32'd1);
    wr(12'h014, 32'd0);
    chk("R8", "queueReset after disable", 32'(queueReset), 32'd1);
    rdChk("R8", 12'h014, 32'd0);
    rdChk("R8", 12'h01C, fail ? 32'h2 : 32'h0);
    queuesLive = 1'b0;
    tick();
    chk("R8", "queueReset one cycle", 32'(queueReset), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R1 watchdog expired: got running expected finished");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] m;
    logic [31:0] lcg;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    for (int w = 3; w < 14; w++) rdChk("R1", 12'(w * 4), 32'd0);
    chk("R1", "queueReset", 32'(queueReset), 32'd0);
    chk("R1", "shutdownReq", 32'(shutdownReq), 32'd0);

    // R2 constants, writes ignored
    rdChk("R2", 12'h000, 32'h0F03_07FF);
    rdChk("R2", 12'h004, 32'h0040_0020);
    rdChk("R2", 12'h008, 32'h0001_0100);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h004, 32'h0);
    wr(12'h008, 32'h1234_5678);
    rdChk("R2", 12'h000, 32'h0F03_07FF);
    rdChk("R2", 12'h004, 32'h0040_0020);
    rdChk("R2", 12'h008, 32'h0001_0100);

    // R3 mask set/clear sweep
    m = 0;
    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 24; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (i % 3 == 2) begin
        wr(12'h010, lcg);
        m = m & ~lcg;
      end else begin
        wr(12'h00C, lcg & 32'h0F0F_F00F);
        m = m | (lcg & 32'h0F0F_F00F);
      end
      rdChk("R3", 12'h00C, m);
      rdChk("R3", 12'h010, m);
    end
    wr(12'h010, 32'hFFFF_FFFF);
    rdChk("R3", 12'h00C, 32'd0);

    // R4 admin registers, independent words
    wr(12'h024, 32'hFFFF_FFFF);
    wr(12'h028, 32'hA5A5_1000);
    wr(12'h02C, 32'h0000_0077);
    wr(12'h030, 32'h5A5A_2000);
    wr(12'h034, 32'h0000_0088);
    rdChk("R4", 12'h024, 32'hFFFF_FFFF);
    rdChk("R4", 12'h028, 32'hA5A5_1000);
    rdChk("R4", 12'h02C, 32'h0000_0077);
    rdChk("R4", 12'h030, 32'h5A5A_2000);
    rdChk("R4", 12'h034, 32'h0000_0088);
    wr(12'h02C, 32'h0000_0001);
    rdChk("R4", 12'h028, 32'hA5A5_1000);
    rdChk("R4", 12'h02C, 32'h0000_0001);

    // R12 unlisted offsets
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h038, 32'hFFFF_FFFF);
    wr(12'h03C, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'hFFFF_FFFF);
    rdChk("R12", 12'h018, 32'd0);
    rdChk("R12", 12'h020, 32'd0);
    rdChk("R12", 12'h038, 32'd0);
    rdChk("R12", 12'hFFC, 32'd0);
    rdChk("R12", 12'h00C, 32'd0);
    rdChk("R12", 12'h014, 32'd0);
    rdChk("R12", 12'h01C, 32'd0);
    rdChk("R12", 12'h00B, 32'h0001_0100);
    chk("R12", "no pulse from unlisted write", 32'(queueReset), 32'd0);

    // R5 baseline success
    trial(64'h1000_0000, 64'h2000_0000, 32'h001F_001F, GOOD, 1'b0, "R5");

    // R6 page code sweep with bases aligned for every code
    for (int p = 0; p < 16; p++)
      trial(64'h1_0000_0000, 64'h2_0000_0000, 32'h0003_0003,
            GOOD | 32'(p << 7), 1'b0, "R6");
    // R6 entry exponent sweeps
    for (int e = 0; e < 16; e++)
      trial(64'h1_0000_0000, 64'h2_0000_0000, 32'h0003_0003,
            (GOOD & ~32'h000F_0000) | 32'(e << 16), 1'b0, "R6");
    for (int e = 0; e < 16; e++)
      trial(64'h1_0000_0000, 64'h2_0000_0000, 32'h0003_0003,
            (GOOD & ~32'h00F0_0000) | 32'(e << 20), 1'b0, "R6");
    // R6 alignment grid: base aligned to 2^(12+k), page code p
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < 5; p++) begin
        trial(64'h1000 << k, 64'h1_0000_0000, 32'h0001_0001,
              GOOD | 32'(p << 7), 1'b0, "R6");
        trial(64'h1_0000_0000, 64'h1000 << k, 32'h0001_0001,
              GOOD | 32'(p << 7), 1'b0, "R6");
      end
    // R6 zero bases and zero sizes
    trial(64'h0, 64'h2000_0000, 32'h0001_0001, GOOD, 1'b0, "R6");
    trial(64'h1000_0000, 64'h0, 32'h0001_0001, GOOD, 1'b0, "R6");
    trial(64'h1000_0000, 64'h2000_0000, 32'h0001_0000, GOOD, 1'b0, "R6");
    trial(64'h1000_0000, 64'h2000_0000, 32'h0000_0001, GOOD, 1'b0, "R6");
    // R7 queues still alive
    trial(64'h1000_0000, 64'h2000_0000, 32'h0001_0001, GOOD, 1'b1, "R7");

    // R9 / R10 / R11 while enabled
    trial(64'h1000_0000, 64'h2000_0000, 32'h0001_0001, GOOD, 1'b0, "R5");
    wr(12'h014, GOOD | 32'd1);
    tick();
    rdChk("R5", 12'h01C, 32'h1);
    wr(12'h014, GOOD | 32'd1 | 32'(3 << 7));
    chk("R9", "no pulse", 32'(queueReset), 32'd0);
    rdChk("R9", 12'h014, GOOD | 32'd1);
    rdChk("R9", 12'h01C, 32'h1);
    wr(12'h014, GOOD | 32'd1 | 32'h4000);
    chk("R10", "queueReset", 32'(queueReset), 32'd1);
    chk("R10", "shutdownReq", 32'(shutdownReq), 32'd1);
    rdChk("R10", 12'h01C, 32'h9);
    rdChk("R10", 12'h014, GOOD | 32'd1 | 32'h4000);
    tick();
    chk("R10", "shutdownReq one cycle", 32'(shutdownReq), 32'd0);
    chk("R10", "queueReset one cycle", 32'(queueReset), 32'd0);
    wr(12'h014, GOOD | 32'd1 | 32'h8000);
    chk("R9", "no pulse nonzero to nonzero", 32'(shutdownReq), 32'd0);
    rdChk("R9", 12'h014, GOOD | 32'd1 | 32'h4000);
    wr(12'h014, GOOD | 32'd1);
    chk("R11", "no reset pulse", 32'(queueReset), 32'd0);
    chk("R11", "no shutdown pulse", 32'(shutdownReq), 32'd0);
    rdChk("R11", 12'h01C, 32'h1);
    rdChk("R11", 12'h014, GOOD | 32'd1);
    wr(12'h014, 32'd0);
    rdChk("R8", 12'h01C, 32'h0);

    // R10 / R11 while disabled
    wr(12'h014, 32'h8000);
    chk("R10", "queueReset disabled", 32'(queueReset), 32'd1);
    chk("R10", "shutdownReq disabled", 32'(shutdownReq), 32'd1);
    rdChk("R10", 12'h014, 32'h8000);
    rdChk("R10", 12'h01C, 32'h8);
    wr(12'h014, 32'h0);
    chk("R11", "no pulse disabled", 32'(queueReset), 32'd0);
    rdChk("R11", 12'h014, 32'h0);
    rdChk("R11", 12'h01C, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule